// File: doc/BRIEF.md
# Two-Level Wait Mode Controller

This block sits beside a small microcontroller core and puts it into one of two halt depths. The core raises a one-cycle wait request carrying a single depth bit. A light wait (depth 0) gates only the CPU clock, so peripherals and timekeeping keep running. A deep wait (depth 1) gates every clock except the crystal oscillator. In the deep wait the output port registers are frozen and all LCD drive lines are forced low. The PLL is switched off in both depths. The controller watches its wake sources and, when one fires, returns the core to run. The core then continues at the instruction after the wait, with no settling delay.

A wait request is only accepted if the core has read the HOLD input since the previous entry. A request that is not armed this way is dropped and the core keeps running. HOLD also has a separate path: when a software control bit is set, a low level on HOLD switches the PLL off even while the core runs. HOLD and the general wake pins are asynchronous. Each passes through a synchronizer on the oscillator clock, and a change is detected against a snapshot of the levels taken at the moment of entry.

Top module: `lpw_ctrl`

## Requirements
- R1: After reset the controller is in run: `mode_state` = 2'b00, `cpu_clk_en` = 1, `wake_pulse` = 0, and it is disarmed.
- R2: An accepted request with `req_hard` = 0 moves the controller to light wait on the next clock edge. In that state `mode_state` = 2'b01, `cpu_clk_en` = 0, `periph_clk_en` = 1 and `lcd_force_low` = 0.
- R3: An accepted request with `req_hard` = 1 moves the controller to deep wait on the next edge. In that state `mode_state` = 2'b10, `cpu_clk_en` = 0, `periph_clk_en` = 0, `lcd_force_low` = 1, `port_hold` = 1 and `osc_en` = 1.
- R4: In either wait state `pll_en` is 0, whatever the value of `pll_sw_en`.
- R5: A level change on `hold_pin` in either direction ends either wait. `mode_state` reads run on the third rising edge after the pin changes: two synchronizer stages, then the state register.
- R6: A level change on bit i of `io_pins` ends either wait, with the same three-edge latency, only when `io_dir[i]` = 1 (input). When `io_dir[i]` = 0, a change on that pin does not end the wait.
- R7: `tick_2hz` = 1 during light wait returns the controller to run on the next edge. During deep wait it is ignored.
- R8: `wake_pulse` is 1 for exactly the first run cycle after a wait and is 0 otherwise.
- R9: A request is accepted only if `hold_read` was pulsed since reset or since the previous entry. Otherwise the request is dropped and `mode_state` stays 2'b00. Each entry uses up the arming.
- R10: In run, `pll_en` = `pll_sw_en`, except that when `pll_hold_off_en` = 1 and the synchronized HOLD level is 0, `pll_en` = 0.
- R11: `hold_level` follows `hold_pin` two rising edges after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle wait request from the core |
| req_hard | input | 1 | Wait depth: 0 light, 1 deep |
| hold_read | input | 1 | Pulse when the core reads the HOLD port |
| hold_pin | input | 1 | Asynchronous HOLD input |
| io_pins | input | N_PINS | Asynchronous general I/O pin levels |
| io_dir | input | N_PINS | Per-pin direction, 1 = input |
| tick_2hz | input | 1 | 2 Hz timer flag |
| pll_sw_en | input | 1 | PLL enable requested by software |
| pll_hold_off_en | input | 1 | Lets a low HOLD level switch the PLL off |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| lcd_force_low | output | 1 | Forces all LCD drive lines low |
| port_hold | output | 1 | Freezes output port registers |
| hold_level | output | 1 | Synchronized HOLD level for the core to read |
| mode_state | output | 2 | 00 run, 01 light wait, 10 deep wait |
| wake_pulse | output | 1 | One-cycle pulse on return to run |

## Verification
The bench sweeps both depths against every wake source: HOLD rising and falling, each I/O pin set as input and as output, and the timer flag. For each case it computes whether a wake should occur. A design that took the timer flag in deep wait, or that ignored pin direction, would leave the wait when it should stay. A design that skipped a synchronizer stage or the snapshot compare would wake one cycle early, or never. The bench also issues requests that are not armed, and repeats a request without a fresh HOLD read. A controller that kept its arming across an entry would halt the core here. The PLL path is checked in run with the HOLD control bit both on and off.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_SOFT = 2'b01,
        ST_HARD = 2'b10
    } lpw_state_e;
endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= '0;
                end else if (s == 0) begin
                    chain_q[s] <= async_i;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lpw_wake.sv
module lpw_wake #(
    parameter int N_PINS = 4
) (
    input  logic              mode_hard,
    input  logic              hold_s,
    input  logic              hold_snap,
    input  logic [N_PINS-1:0] pins_s,
    input  logic [N_PINS-1:0] pins_snap,
    input  logic [N_PINS-1:0] pins_dir,
    input  logic              tick_2hz,
    output logic              wake_any
);
    logic [N_PINS-1:0] pin_hit;
    logic              hold_hit;
    logic              tick_hit;

    always_comb begin
        hold_hit = hold_s ^ hold_snap;
        pin_hit  = (pins_s ^ pins_snap) & pins_dir;
        tick_hit = tick_2hz & ~mode_hard;
        wake_any = hold_hit | (|pin_hit) | tick_hit;
    end
endmodule

// File: rtl/lpw_ctrl.sv
module lpw_ctrl
    import lpw_pkg::*;
#(
    parameter int N_PINS      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_osc,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_hard,
    input  logic              hold_read,
    input  logic              hold_pin,
    input  logic [N_PINS-1:0] io_pins,
    input  logic [N_PINS-1:0] io_dir,
    input  logic              tick_2hz,
    input  logic              pll_sw_en,
    input  logic              pll_hold_off_en,
    output logic              cpu_clk_en,
    output logic              periph_clk_en,
    output logic              osc_en,
    output logic              pll_en,
    output logic              lcd_force_low,
    output logic              port_hold,
    output logic              hold_level,
    output logic [1:0]        mode_state,
    output logic              wake_pulse
);
    localparam int SYNC_W = N_PINS + 1;

    typedef struct packed {
        lpw_state_e        state;
        logic              armed;
        logic              snap_hold;
        logic [N_PINS-1:0] snap_pins;
        logic              wake_pulse;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SYNC_W-1:0] sync_out;
    logic              hold_s;
    logic [N_PINS-1:0] pins_s;
    logic              wake_any;
    logic              in_wait;
    logic              enter;

    lpw_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk_osc),
        .rst_n  (rst_n),
        .async_i({hold_pin, io_pins}),
        .sync_o (sync_out)
    );

    assign hold_s = sync_out[SYNC_W-1];
    assign pins_s = sync_out[N_PINS-1:0];

    lpw_wake #(.N_PINS(N_PINS)) u_wake (
        .mode_hard(ctl_q.state == ST_HARD),
        .hold_s   (hold_s),
        .hold_snap(ctl_q.snap_hold),
        .pins_s   (pins_s),
        .pins_snap(ctl_q.snap_pins),
        .pins_dir (io_dir),
        .tick_2hz (tick_2hz),
        .wake_any (wake_any)
    );

    always_comb begin
        ctl_d            = ctl_q;
        ctl_d.wake_pulse = 1'b0;
        in_wait          = (ctl_q.state != ST_RUN);
        enter            = (ctl_q.state == ST_RUN) && req_valid && ctl_q.armed;
        if (enter) begin
            ctl_d.state     = req_hard ? ST_HARD : ST_SOFT;
            ctl_d.armed     = 1'b0;
            ctl_d.snap_hold = hold_s;
            ctl_d.snap_pins = pins_s;
        end else if (in_wait && wake_any) begin
            ctl_d.state      = ST_RUN;
            ctl_d.wake_pulse = 1'b1;
        end
        if (hold_read && !enter) begin
            ctl_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_RUN, armed: 1'b0, snap_hold: 1'b0,
                       snap_pins: '0, wake_pulse: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        cpu_clk_en    = (ctl_q.state == ST_RUN);
        periph_clk_en = (ctl_q.state != ST_HARD);
        osc_en        = 1'b1;
        lcd_force_low = (ctl_q.state == ST_HARD);
        port_hold     = (ctl_q.state == ST_HARD);
        pll_en        = pll_sw_en && (ctl_q.state == ST_RUN) &&
                        !(pll_hold_off_en && !hold_s);
        hold_level    = hold_s;
        mode_state    = ctl_q.state;
        wake_pulse    = ctl_q.wake_pulse;
    end

    assert_entry_depth_R2: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (req_valid && ctl_q.armed && ctl_q.state == ST_RUN) |=>
        (ctl_q.state == ($past(req_hard) ? ST_HARD : ST_SOFT)));

    assert_pll_off_wait_R4: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (ctl_q.state != ST_RUN) |-> !pll_en);

    assert_hard_ignores_tick_R7: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (ctl_q.state == ST_HARD && !wake_any) |=> (ctl_q.state == ST_HARD));

    assert_soft_tick_wakes_R7: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (ctl_q.state == ST_SOFT && tick_2hz) |=> (ctl_q.state == ST_RUN));

    assert_wake_pulse_edge_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
        wake_pulse |-> (ctl_q.state == ST_RUN && $past(ctl_q.state) != ST_RUN));

    assert_wake_pulse_single_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    assert_unarmed_drop_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (req_valid && !ctl_q.armed && ctl_q.state == ST_RUN && !hold_read) |=>
        (ctl_q.state == ST_RUN));
endmodule

// File: tb/sim_lpw_ctrl.sv
module sim_lpw_ctrl;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_hard = 0, hold_read = 0, hold_pin = 0;
    logic [N-1:0] io_pins = '0, io_dir = '0;
    logic tick_2hz = 0, pll_sw_en = 0, pll_hold_off_en = 0;
    logic cpu_clk_en, periph_clk_en, osc_en, pll_en, lcd_force_low, port_hold, hold_level;
    logic [1:0] mode_state;
    logic wake_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    lpw_ctrl #(.N_PINS(N), .SYNC_STAGES(2)) u0 (
        .clk_osc(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hard(req_hard),
        .hold_read(hold_read), .hold_pin(hold_pin), .io_pins(io_pins), .io_dir(io_dir),
        .tick_2hz(tick_2hz), .pll_sw_en(pll_sw_en), .pll_hold_off_en(pll_hold_off_en),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
        .pll_en(pll_en), .lcd_force_low(lcd_force_low), .port_hold(port_hold),
        .hold_level(hold_level), .mode_state(mode_state), .wake_pulse(wake_pulse)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic arm_and_enter(input bit hard);
        hold_read = 1; step(1); hold_read = 0;
        req_valid = 1; req_hard = hard; step(1); req_valid = 0;
    endtask

    task automatic check_wait_outputs(input bit hard);
        chk(mode_state == (hard ? 2'b10 : 2'b01), hard ? "R3 state" : "R2 state",
            int'(mode_state), hard ? 2 : 1);
        chk(cpu_clk_en == 0, "R2/R3 cpu gate", int'(cpu_clk_en), 0);
        chk(periph_clk_en == !hard, hard ? "R3 periph" : "R2 periph", int'(periph_clk_en), int'(!hard));
        chk(lcd_force_low == hard, hard ? "R3 lcd" : "R2 lcd", int'(lcd_force_low), int'(hard));
        chk(port_hold == hard, "R3 port hold", int'(port_hold), int'(hard));
        chk(osc_en == 1, "R3 osc", int'(osc_en), 1);
        chk(pll_en == 0, "R4 pll off in wait", int'(pll_en), 0);
    endtask

    task automatic expect_wake(input string req);
        step(2);
        chk(mode_state != 2'b00, {req, " latency not early"}, int'(mode_state), 99);
        step(1);
        chk(mode_state == 2'b00, {req, " woke"}, int'(mode_state), 0);
        chk(cpu_clk_en == 1, {req, " cpu back"}, int'(cpu_clk_en), 1);
        chk(wake_pulse == 1, "R8 pulse high", int'(wake_pulse), 1);
        step(1);
        chk(wake_pulse == 0, "R8 pulse one cycle", int'(wake_pulse), 0);
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        chk(mode_state == 2'b00, "R1 reset state", int'(mode_state), 0);
        chk(cpu_clk_en == 1, "R1 cpu en", int'(cpu_clk_en), 1);
        chk(wake_pulse == 0, "R1 wake", int'(wake_pulse), 0);

        // R9: disarmed after reset, request dropped
        req_valid = 1; req_hard = 1; step(1); req_valid = 0;
        chk(mode_state == 2'b00, "R9 unarmed drop after reset", int'(mode_state), 0);

        // R11 and R10 in run
        pll_sw_en = 1; pll_hold_off_en = 0; hold_pin = 0; step(3);
        chk(pll_en == 1, "R10 no hold control", int'(pll_en), 1);
        pll_hold_off_en = 1; step(1);
        chk(pll_en == 0, "R10 hold low forces off", int'(pll_en), 0);
        hold_pin = 1; step(1);
        chk(hold_level == 0, "R11 one edge not yet", int'(hold_level), 0);
        step(1);
        chk(hold_level == 1, "R11 two edges", int'(hold_level), 1);
        chk(pll_en == 1, "R10 hold high releases", int'(pll_en), 1);
        pll_hold_off_en = 0;

        for (int hard = 0; hard < 2; hard++) begin
            // HOLD both directions
            for (int dirn = 0; dirn < 2; dirn++) begin
                hold_pin = dirn[0]; step(3);
                arm_and_enter(hard[0]);
                check_wait_outputs(hard[0]);
                hold_pin = ~hold_pin;
                expect_wake("R5 hold change");
            end
            // each I/O pin, as input and as output
            for (int i = 0; i < N; i++) begin
                for (int dm = 0; dm < 2; dm++) begin
                    io_dir = dm ? (N'(1) << i) : ~(N'(1) << i);
                    step(3);
                    arm_and_enter(hard[0]);
                    check_wait_outputs(hard[0]);
                    io_pins[i] = ~io_pins[i];
                    if (dm == 1) begin
                        expect_wake("R6 input pin");
                    end else begin
                        step(6);
                        chk(mode_state == (hard ? 2'b10 : 2'b01), "R6 output pin ignored",
                            int'(mode_state), hard ? 2 : 1);
                        hold_pin = ~hold_pin;
                        expect_wake("R5 release");
                    end
                end
            end
            // timer flag
            io_dir = '0; step(3);
            arm_and_enter(hard[0]);
            tick_2hz = 1; step(1); tick_2hz = 0;
            if (hard == 0) begin
                chk(mode_state == 2'b00, "R7 tick wakes light wait", int'(mode_state), 0);
                chk(wake_pulse == 1, "R8 pulse on tick", int'(wake_pulse), 1);
            end else begin
                step(4);
                chk(mode_state == 2'b10, "R7 tick ignored in deep wait", int'(mode_state), 2);
                hold_pin = ~hold_pin;
                expect_wake("R5 release");
            end
            // R9: arming consumed by entry
            step(2);
            req_valid = 1; req_hard = hard[0]; step(1); req_valid = 0;
            chk(mode_state == 2'b00, "R9 rearm needed", int'(mode_state), 0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule